// File: doc/BRIEF.md
# Bit-Logic Result Accumulator Executor

This block runs a stream of single-bit logic instructions, one per clock, in the manner of a programmable controller's scan. It holds one result bit, a flag that tells whether a logic chain is open, a small bit memory and a separate edge-history memory of the same size. Each instruction carries an opcode and an operand index. Logic instructions fold the addressed memory bit into the result bit. Store instructions write the result bit back into memory. Edge instructions compare the result bit with that index's history bit and then update the history bit.

A scan-start pulse marks the boundary between controller cycles and closes any open chain. The result bit is always visible. Any memory bit can be read combinationally through a separate read address. The memory must hold a power-of-two number of bits.

Top module: `bitlogic_exec`

## Requirements
- R1: When no chain is open, AND (op 2), ANDN (op 3), OR (op 4), ORN (op 5), XOR (op 6) and XORN (op 7) load the addressed bit into the result. The odd opcodes load its inverse. After the instruction a chain is open.
- R2: While a chain is open, those same opcodes combine the addressed bit with the result, and the odd opcodes invert the bit first. AND and ANDN combine with AND, OR and ORN with OR, XOR and XORN with exclusive-or.
- R3: ASSIGN (op 10) copies the result into the addressed bit and closes the chain. The result itself is unchanged.
- R4: SET (op 8) forces the result to 1 and CLR (op 9) forces it to 0. Neither reads memory, and both close the chain.
- R5: NOT (op 1) inverts the result and leaves the chain state unchanged. Op 0 and op 15 change nothing.
- R6: SETB (op 11) writes 1 and RSTB (op 12) writes 0 to the addressed bit only when the result is 1. Both leave the result unchanged and close the chain, so several may follow one result.
- R7: POS (op 13) makes the result 1 only if the result was 1 and the addressed history bit was 0. It then stores the old result in that history bit and leaves a chain open.
- R8: NEG (op 14) makes the result 1 only if the result was 0 and the addressed history bit was 1. It then stores the old result in that history bit and leaves a chain open.
- R9: scan_start closes the chain. An instruction issued in the same cycle sees no open chain.
- R10: With ins_valid low, neither the result nor the bit memory changes.
- R11: A synchronous reset clears the result, the chain flag, the bit memory and the history memory.
- R12: An edge result, once fed to ASSIGN in each scan, is high for exactly one scan after its input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_start | input | 1 | Scan boundary pulse |
| ins_valid | input | 1 | Instruction valid |
| ins_op | input | 4 | Opcode |
| ins_addr | input | AW | Operand index |
| rd_addr | input | AW | Bit-memory read index |
| rd_bit | output | 1 | Memory bit at rd_addr |
| rlo | output | 1 | Current result bit |

## Verification
The bench drives the chain-opening flag through every path: a first logic instruction after ASSIGN, SET, CLR, SETB or scan_start, and a logic instruction that coincides with scan_start. A design that combined instead of loading at those points would carry a stale result into the new chain. It issues SETB and RSTB with a result of 0 and expects memory to stay put, which catches an unconditional write. It runs edge scans over several cycles to show the pulse lasts one scan. A design that stored the new result rather than the old one in the history bit would give a pulse that is stuck or never appears.

// File: rtl/bitlogic_exec.sv
`timescale 1ns/1ps
module bitlogic_exec #(
  parameter int MEM_BITS = 16,
  localparam int AW = $clog2(MEM_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scan_start,
  input  logic          ins_valid,
  input  logic [3:0]    ins_op,
  input  logic [AW-1:0] ins_addr,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit,
  output logic          rlo
);
  localparam logic [3:0] OP_NOT  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_ANDN = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_ORN  = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_XORN = 4'd7;
  localparam logic [3:0] OP_SET  = 4'd8;
  localparam logic [3:0] OP_CLR  = 4'd9;
  localparam logic [3:0] OP_ASN  = 4'd10;
  localparam logic [3:0] OP_SETB = 4'd11;
  localparam logic [3:0] OP_RSTB = 4'd12;
  localparam logic [3:0] OP_POS  = 4'd13;
  localparam logic [3:0] OP_NEG  = 4'd14;

  logic [MEM_BITS-1:0] bits_q, bits_d, hist_q, hist_d;
  logic rlo_q, rlo_d, open_q, open_d;

  wire open_eff = open_q & ~scan_start;
  wire opnd     = bits_q[ins_addr] ^ ins_op[0];
  wire hist_bit = hist_q[ins_addr];

  always_comb begin
    rlo_d  = rlo_q;
    open_d = open_eff;
    bits_d = bits_q;
    hist_d = hist_q;
    if (ins_valid) begin
      case (ins_op)
        OP_NOT: rlo_d = ~rlo_q;
        OP_AND, OP_ANDN: begin
          rlo_d  = open_eff ? (rlo_q & opnd) : opnd;
          open_d = 1'b1;
        end
        OP_OR, OP_ORN: begin
          rlo_d  = open_eff ? (rlo_q | opnd) : opnd;
          open_d = 1'b1;
        end
        OP_XOR, OP_XORN: begin
          rlo_d  = open_eff ? (rlo_q ^ opnd) : opnd;
          open_d = 1'b1;
        end
        OP_SET: begin rlo_d = 1'b1; open_d = 1'b0; end
        OP_CLR: begin rlo_d = 1'b0; open_d = 1'b0; end
        OP_ASN: begin bits_d[ins_addr] = rlo_q; open_d = 1'b0; end
        OP_SETB: begin
          if (rlo_q) bits_d[ins_addr] = 1'b1;
          open_d = 1'b0;
        end
        OP_RSTB: begin
          if (rlo_q) bits_d[ins_addr] = 1'b0;
          open_d = 1'b0;
        end
        OP_POS: begin
          rlo_d = rlo_q & ~hist_bit;
          hist_d[ins_addr] = rlo_q;
          open_d = 1'b1;
        end
        OP_NEG: begin
          rlo_d = ~rlo_q & hist_bit;
          hist_d[ins_addr] = rlo_q;
          open_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rlo_q  <= 1'b0;
      open_q <= 1'b0;
      bits_q <= '0;
      hist_q <= '0;
    end else begin
      rlo_q  <= rlo_d;
      open_q <= open_d;
      bits_q <= bits_d;
      hist_q <= hist_d;
    end
  end

  assign rlo    = rlo_q;
  assign rd_bit = bits_q[rd_addr];
endmodule

module bitlogic_exec_chk #(
  parameter int MEM_BITS = 16,
  localparam int AW = $clog2(MEM_BITS)
) (
  input logic                clk,
  input logic                rst,
  input logic                scan_start,
  input logic                ins_valid,
  input logic [3:0]          ins_op,
  input logic [AW-1:0]       ins_addr,
  input logic                rlo,
  input logic                open,
  input logic [MEM_BITS-1:0] bits,
  input logic [MEM_BITS-1:0] hist
);
  a_r1_first_load: assert property (@(posedge clk) disable iff (rst)
    ins_valid && ins_op == 4'd2 && (!open || scan_start) |=> rlo == $past(bits[ins_addr]));

  a_r2_and_chain: assert property (@(posedge clk) disable iff (rst)
    ins_valid && ins_op == 4'd2 && open && !scan_start |=> rlo == ($past(rlo) & $past(bits[ins_addr])));

  a_r3_assign: assert property (@(posedge clk) disable iff (rst)
    ins_valid && ins_op == 4'd10 |=> bits[$past(ins_addr)] == $past(rlo) && !open && $stable(rlo));

  a_r4_set: assert property (@(posedge clk) disable iff (rst)
    ins_valid && ins_op == 4'd8 |=> rlo && !open);

  a_r4_clr: assert property (@(posedge clk) disable iff (rst)
    ins_valid && ins_op == 4'd9 |=> !rlo && !open);

  a_r6_gate: assert property (@(posedge clk) disable iff (rst)
    ins_valid && (ins_op == 4'd11 || ins_op == 4'd12) && !rlo |=> $stable(bits) && !rlo);

  a_r7_pos_hist: assert property (@(posedge clk) disable iff (rst)
    ins_valid && ins_op == 4'd13 |=> hist[$past(ins_addr)] == $past(rlo));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |=> $stable(rlo) && $stable(bits));

  a_r11_reset: assert property (@(posedge clk)
    rst |=> !rlo && !open && bits == '0 && hist == '0);
endmodule

bind bitlogic_exec bitlogic_exec_chk #(.MEM_BITS(MEM_BITS)) u_chk (
  .clk(clk), .rst(rst), .scan_start(scan_start), .ins_valid(ins_valid),
  .ins_op(ins_op), .ins_addr(ins_addr), .rlo(rlo_q), .open(open_q),
  .bits(bits_q), .hist(hist_q)
);

// File: tb/tb_bitlogic_exec.sv
`timescale 1ns/1ps
module tb_bitlogic_exec;
  localparam int N  = 16;
  localparam int AW = $clog2(N);

  logic clk = 1'b0, rst = 1'b1, scan_start = 1'b0, ins_valid = 1'b0;
  logic [3:0] ins_op = '0;
  logic [AW-1:0] ins_addr = '0, rd_addr = '0;
  logic rd_bit, rlo;

  bitlogic_exec #(.MEM_BITS(N)) dut (
    .clk(clk), .rst(rst), .scan_start(scan_start), .ins_valid(ins_valid),
    .ins_op(ins_op), .ins_addr(ins_addr), .rd_addr(rd_addr),
    .rd_bit(rd_bit), .rlo(rlo)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [N-1:0] m_bits, m_hist;
  logic m_rlo, m_open;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic v, input logic [3:0] op, input logic first);
    if (!v) return "R10";
    case (op)
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: return first ? "R1" : "R2";
      4'd8, 4'd9: return "R4";
      4'd10: return "R3";
      4'd11, 4'd12: return "R6";
      4'd13: return "R7";
      4'd14: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic model(input logic v, input logic [3:0] op, input int a, input logic ss);
    logic op_open, x;
    op_open = m_open & ~ss;
    x = m_bits[a] ^ op[0];
    m_open = op_open;
    if (v) begin
      case (op)
        4'd1: m_rlo = ~m_rlo;
        4'd2, 4'd3: begin m_rlo = op_open ? (m_rlo & x) : x; m_open = 1; end
        4'd4, 4'd5: begin m_rlo = op_open ? (m_rlo | x) : x; m_open = 1; end
        4'd6, 4'd7: begin m_rlo = op_open ? (m_rlo ^ x) : x; m_open = 1; end
        4'd8: begin m_rlo = 1; m_open = 0; end
        4'd9: begin m_rlo = 0; m_open = 0; end
        4'd10: begin m_bits[a] = m_rlo; m_open = 0; end
        4'd11: begin if (m_rlo) m_bits[a] = 1; m_open = 0; end
        4'd12: begin if (m_rlo) m_bits[a] = 0; m_open = 0; end
        4'd13: begin x = m_rlo & ~m_hist[a]; m_hist[a] = m_rlo; m_rlo = x; m_open = 1; end
        4'd14: begin x = ~m_rlo & m_hist[a]; m_hist[a] = m_rlo; m_rlo = x; m_open = 1; end
        default: ;
      endcase
    end
  endtask

  task automatic exec(input logic v, input logic [3:0] op, input int a, input logic ss);
    string tag;
    tag = tag_of(v, op, !(m_open & ~ss));
    if (ss && v && op >= 4'd2 && op <= 4'd7 && m_open) tag = "R9";
    ins_valid = v; ins_op = op; ins_addr = AW'(a); scan_start = ss;
    @(posedge clk);
    model(v, op, a, ss);
    @(negedge clk);
    ins_valid = 0; scan_start = 0;
    check({tag, " rlo"}, rlo, m_rlo);
    rd_addr = AW'(a);
    #1;
    check({tag, " bit"}, rd_bit, m_bits[a]);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < N; i++) begin
      rd_addr = AW'(i);
      #0.5;
      check(tag, rd_bit, m_bits[i]);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_bits = '0; m_hist = '0; m_rlo = 0; m_open = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R11 rlo", rlo, 1'b0);
    sweep("R11 mem");

    // R1/R2 chain loading and combining
    exec(1, 4'd8, 0, 0);
    exec(1, 4'd10, 1, 0);
    exec(1, 4'd2, 1, 0);
    exec(1, 4'd3, 1, 0);
    exec(1, 4'd6, 1, 0);
    exec(1, 4'd5, 0, 0);
    exec(1, 4'd1, 0, 0);
    exec(1, 4'd10, 2, 0);
    exec(1, 4'd3, 0, 0);
    exec(1, 4'd9, 0, 0);
    exec(1, 4'd4, 1, 0);
    // R9: chain open, scan_start with AND loads
    exec(1, 4'd2, 0, 1);
    check("R9 load", rlo, 1'b0);
    // R6 gated writes with result 0
    exec(1, 4'd11, 5, 0);
    exec(1, 4'd12, 1, 0);
    check("R6 kept", rd_bit, 1'b1);
    exec(1, 4'd8, 0, 0);
    exec(1, 4'd11, 6, 0);
    exec(1, 4'd11, 7, 0);
    exec(1, 4'd12, 1, 0);
    // R12 one-scan pulses via edges
    for (int s = 0; s < 6; s++) begin
      exec(1, (s >= 1 && s <= 3) ? 4'd8 : 4'd9, 0, 1);
      exec(1, 4'd10, 3, 0);
      exec(1, 4'd2, 3, 0);
      exec(1, 4'd13, 4, 0);
      exec(1, 4'd10, 8, 0);
      check("R12 pos", rd_bit, s == 1);
      exec(1, 4'd2, 3, 0);
      exec(1, 4'd14, 5, 0);
      exec(1, 4'd10, 9, 0);
      check("R12 neg", rd_bit, s == 4);
    end
    // R10 idle with garbage
    for (int i = 0; i < 4; i++) exec(0, 4'(i + 8), i, 0);
    // random mix
    for (int i = 0; i < 3000; i++)
      exec(($urandom % 6) != 0, 4'($urandom % 16), int'($urandom % N), ($urandom % 8) == 0);
    sweep("R3 mem");
    // reset mid-run
    rst = 1;
    @(posedge clk);
    m_bits = '0; m_hist = '0; m_rlo = 0; m_open = 0;
    @(negedge clk);
    rst = 0;
    check("R11 rlo2", rlo, 1'b0);
    sweep("R11 mem2");
    exec(1, 4'd8, 0, 0);
    exec(1, 4'd13, 0, 0);
    check("R11 hist", rlo, 1'b1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule